// File: doc/BRIEF.md
# String Operation Repeat Sequencer

This block carries out a single string primitive of a 16-bit processor, either once or in a loop under a repeat prefix. Five primitives are supported: move, compare, scan, load and store. Each one works on a byte or on a word. A start pulse captures the source index, destination index, count, accumulator, direction flag and the six arithmetic flags. The sequencer then talks to a byte-wide memory port. That port uses a request/ready handshake.

When the work is finished the block raises done for one cycle. The updated indices, count, accumulator and flags are held on its outputs. A word access is made as two byte transfers, low byte first at the lower address. Under a repeat prefix the count is tested before every iteration and decremented after each one. Compare and scan can also end the loop early, depending on the zero flag.

Top module: `strop_seq`

## Requirements
- R1: After each primitive, an index the primitive uses steps by +1 (byte) or +2 (word) when `dir` is 0, and by -1 or -2 when `dir` is 1. The arithmetic wraps modulo 2^16.
- R2: Compare (`op_sel`=1) reads [SI] and then [DI] and forms [SI]-[DI]. It writes nothing and advances both indices. It sets all six flags, packed in `flags_out` as bit0 carry (borrow), bit1 parity (even parity of the low result byte), bit2 auxiliary (borrow out of bit 3), bit3 zero, bit4 sign, bit5 overflow.
- R3: Scan (`op_sel`=2) forms accumulator minus [DI], sets the flags as in R2 and advances only DI.
- R4: Load (`op_sel`=3) reads [SI] into the accumulator and advances only SI. A byte load replaces only bits 7:0 of the accumulator.
- R5: Move (`op_sel`=0) copies [SI] to [DI] and advances both indices. The flags are left as loaded.
- R6: Store (`op_sel`=4) writes the accumulator (its low byte for byte size) to [DI] and advances only DI.
- R7: A word access is two byte transfers. The low byte goes at the index address and the high byte at the index plus 1, with the address wrapping modulo 2^16.
- R8: With `rep_sel`=1 the loop tests the count for zero, performs the primitive, and decrements the count by one, with no change to the flags. It stops when the count is zero at the test.
- R9: With `rep_sel`=2, compare and scan also stop after an iteration that leaves zero clear. With `rep_sel`=3 they stop after one that leaves zero set.
- R10: For move, load and store, `rep_sel`=2 and `rep_sel`=3 behave exactly like `rep_sel`=1.
- R11: Under any repeat prefix, a count of zero at start makes no memory transfer and returns every register unchanged.
- R12: With `rep_sel`=0 the primitive runs exactly once, and the count is returned unchanged even if it is zero.
- R13: While a request waits for ready, its address, direction and write data stay constant. Done is a one-cycle pulse. After reset the block is idle with no request and all result outputs at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken when idle) |
| op_sel | input | 3 | Primitive: 0 move, 1 compare, 2 scan, 3 load, 4 store |
| wide | input | 1 | 1 = word, 0 = byte |
| rep_sel | input | 2 | 0 none, 1 repeat, 2 repeat while equal, 3 repeat while not equal |
| dir | input | 1 | Direction flag, 1 = decrement |
| si_in | input | AW | Source index at start |
| di_in | input | AW | Destination index at start |
| cx_in | input | CW | Count at start |
| acc_in | input | 16 | Accumulator at start |
| flags_in | input | 6 | Arithmetic flags at start |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with ready |
| mem_rdy | input | 1 | Transfer completes on a clock edge with request and ready |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| si_out | output | AW | Source index result |
| di_out | output | AW | Destination index result |
| cx_out | output | CW | Count result |
| acc_out | output | 16 | Accumulator result |
| flags_out | output | 6 | Flags result |

## Verification
The reset synchronizer releases the logic two edges after `rst_n` rises. A start pulse is accepted at the next edge. After that the completion time depends on the stalls drawn on ready, so the bench never predicts a fixed latency. It samples on falling edges until done is seen and reads all results in that same half-cycle, while they are held. One falling edge later it checks that done has dropped. Memory contents and the number of completed byte transfers are counted at the rising edges where request and ready are both high, then compared with the model once done appears.

// File: rtl/strop_pkg.sv
package strop_pkg;
  localparam int DW = 16;
  localparam int BW = 8;
  localparam int FW = 6;

  localparam int FL_CF = 0;
  localparam int FL_PF = 1;
  localparam int FL_AF = 2;
  localparam int FL_ZF = 3;
  localparam int FL_SF = 4;
  localparam int FL_OF = 5;

  typedef enum logic [2:0] {
    OP_MOVE  = 3'd0,
    OP_CMP   = 3'd1,
    OP_SCAN  = 3'd2,
    OP_LOAD  = 3'd3,
    OP_STORE = 3'd4
  } str_op_e;

  typedef enum logic [1:0] {
    RP_NONE = 2'd0,
    RP_ALL  = 2'd1,
    RP_EQ   = 2'd2,
    RP_NE   = 2'd3
  } rep_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_RSRC, ST_RDST, ST_WDST, ST_UPD, ST_FIN
  } seq_st_e;
endpackage

// File: rtl/strop_idx.sv
module strop_idx #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cur,
  input  logic          dir,
  input  logic          wide,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] STEP_B = AW'(1);
  localparam logic [AW-1:0] STEP_W = AW'(2);

  logic [AW-1:0] step;

  always_comb begin
    step = wide ? STEP_W : STEP_B;
    nxt  = dir ? (cur - step) : (cur + step);
  end
endmodule

// File: rtl/strop_flags.sv
module strop_flags
  import strop_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          wide,
  output logic [FW-1:0] fl
);
  logic [DW-1:0] diff;
  logic [DW-1:0] carry_vec;

  always_comb begin
    diff      = a - b;
    carry_vec = a ^ b ^ diff;
    fl        = '0;
    fl[FL_AF] = carry_vec[4];
    fl[FL_PF] = ~^diff[BW-1:0];
    if (wide) begin
      fl[FL_CF] = (a < b);
      fl[FL_ZF] = (diff == '0);
      fl[FL_SF] = diff[DW-1];
      fl[FL_OF] = (a[DW-1] ^ b[DW-1]) & (diff[DW-1] ^ a[DW-1]);
    end else begin
      fl[FL_CF] = (a[BW-1:0] < b[BW-1:0]);
      fl[FL_ZF] = (diff[BW-1:0] == '0);
      fl[FL_SF] = diff[BW-1];
      fl[FL_OF] = (a[BW-1] ^ b[BW-1]) & (diff[BW-1] ^ a[BW-1]);
    end
  end
endmodule

// File: rtl/strop_xfer.sv
module strop_xfer
  import strop_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_ns,
  input  logic          en,
  input  logic          we,
  input  logic          wide,
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] mem_wdata,
  input  logic [BW-1:0] mem_rdata,
  input  logic          mem_rdy,
  output logic          fin,
  output logic [DW-1:0] rdata
);
  logic          hi_q, hi_n;
  logic [BW-1:0] lo_q, lo_n;
  logic          last;

  always_comb begin
    last      = ~wide | hi_q;
    fin       = en & mem_rdy & last;
    mem_req   = en;
    mem_we    = we;
    mem_addr  = base + {{(AW-1){1'b0}}, hi_q};
    mem_wdata = hi_q ? wdata[DW-1:BW] : wdata[BW-1:0];
    rdata     = wide ? {mem_rdata, lo_q} : {{(DW-BW){1'b0}}, mem_rdata};
    hi_n      = hi_q;
    lo_n      = lo_q;
    if (en && mem_rdy) begin
      if (last) begin
        hi_n = 1'b0;
      end else begin
        hi_n = 1'b1;
        lo_n = mem_rdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      hi_q <= 1'b0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_n;
      lo_q <= lo_n;
    end
  end

  assert_req_held_R13: assert property (@(posedge clk) disable iff (!rst_ns)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_word_order_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    (mem_req && mem_rdy && wide && !hi_q) |=> (mem_req && mem_addr == $past(mem_addr) + {{(AW-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/strop_seq.sv
module strop_seq
  import strop_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op_sel,
  input  logic          wide,
  input  logic [1:0]    rep_sel,
  input  logic          dir,
  input  logic [AW-1:0] si_in,
  input  logic [AW-1:0] di_in,
  input  logic [CW-1:0] cx_in,
  input  logic [15:0]   acc_in,
  input  logic [5:0]    flags_in,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_rdy,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] si_out,
  output logic [AW-1:0] di_out,
  output logic [CW-1:0] cx_out,
  output logic [15:0]   acc_out,
  output logic [5:0]    flags_out
);
  localparam logic [CW-1:0] CX_ONE = CW'(1);
  localparam logic [AW-1:0] A_ONE  = AW'(1);
  localparam logic [AW-1:0] A_TWO  = AW'(2);
  localparam int            NIDX   = 2;

  logic [1:0] rs_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  seq_st_e       st_q, st_n;
  str_op_e       op_q, op_n;
  rep_e          rep_q, rep_n;
  logic          wide_q, wide_n, dir_q, dir_n;
  logic [AW-1:0] si_q, si_n, di_q, di_n;
  logic [CW-1:0] cx_q, cx_n;
  logic [DW-1:0] acc_q, acc_n, opa_q, opa_n, opb_q, opb_n;
  logic [FW-1:0] flg_q, flg_n, cmp_fl;

  logic          x_en, x_we, x_fin;
  logic [AW-1:0] x_base;
  logic [DW-1:0] x_rd;
  logic          uses_src, uses_dst, is_cmp, zf_exit;

  logic [AW-1:0] idx_cur [NIDX];
  logic [AW-1:0] idx_nxt [NIDX];
  assign idx_cur[0] = si_q;
  assign idx_cur[1] = di_q;

  for (genvar g = 0; g < NIDX; g++) begin : g_step
    strop_idx #(.AW(AW)) u_step (
      .cur (idx_cur[g]),
      .dir (dir_q),
      .wide(wide_q),
      .nxt (idx_nxt[g])
    );
  end

  strop_flags u_flags (
    .a   (opa_q),
    .b   (opb_q),
    .wide(wide_q),
    .fl  (cmp_fl)
  );

  strop_xfer #(.AW(AW)) u_xfer (
    .clk      (clk),
    .rst_ns   (rst_ns),
    .en       (x_en),
    .we       (x_we),
    .wide     (wide_q),
    .base     (x_base),
    .wdata    (opa_q),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .mem_rdy  (mem_rdy),
    .fin      (x_fin),
    .rdata    (x_rd)
  );

  always_comb begin
    uses_src = (op_q == OP_MOVE) || (op_q == OP_CMP) || (op_q == OP_LOAD);
    uses_dst = (op_q != OP_LOAD);
    is_cmp   = (op_q == OP_CMP) || (op_q == OP_SCAN);
    zf_exit  = is_cmp && (((rep_q == RP_EQ) && !cmp_fl[FL_ZF]) ||
                          ((rep_q == RP_NE) &&  cmp_fl[FL_ZF]));
    x_en     = (st_q == ST_RSRC) || (st_q == ST_RDST) || (st_q == ST_WDST);
    x_we     = (st_q == ST_WDST);
    x_base   = (st_q == ST_RSRC) ? si_q : di_q;
    busy     = (st_q != ST_IDLE);
    done     = (st_q == ST_FIN);
  end

  always_comb begin
    st_n = st_q;   op_n = op_q;   rep_n = rep_q;
    wide_n = wide_q; dir_n = dir_q;
    si_n = si_q;   di_n = di_q;   cx_n = cx_q;
    acc_n = acc_q; flg_n = flg_q; opa_n = opa_q; opb_n = opb_q;
    unique case (st_q)
      ST_IDLE: if (start) begin
        op_n   = str_op_e'(op_sel);
        rep_n  = rep_e'(rep_sel);
        wide_n = wide;
        dir_n  = dir;
        si_n   = si_in;
        di_n   = di_in;
        cx_n   = cx_in;
        acc_n  = acc_in;
        flg_n  = flags_in;
        st_n   = ST_CHECK;
      end
      ST_CHECK: begin
        opa_n = acc_q;
        if ((rep_q != RP_NONE) && (cx_q == '0)) st_n = ST_FIN;
        else begin
          case (op_q)
            OP_MOVE, OP_CMP, OP_LOAD: st_n = ST_RSRC;
            OP_SCAN:                  st_n = ST_RDST;
            OP_STORE:                 st_n = ST_WDST;
            default:                  st_n = ST_FIN;
          endcase
        end
      end
      ST_RSRC: if (x_fin) begin
        opa_n = x_rd;
        st_n  = (op_q == OP_MOVE) ? ST_WDST : ((op_q == OP_CMP) ? ST_RDST : ST_UPD);
      end
      ST_RDST: if (x_fin) begin
        opb_n = x_rd;
        st_n  = ST_UPD;
      end
      ST_WDST: if (x_fin) st_n = ST_UPD;
      ST_UPD: begin
        if (uses_src) si_n = idx_nxt[0];
        if (uses_dst) di_n = idx_nxt[1];
        if (is_cmp)   flg_n = cmp_fl;
        if (op_q == OP_LOAD)
          acc_n = wide_q ? opa_q : {acc_q[DW-1:BW], opa_q[BW-1:0]};
        if (rep_q == RP_NONE) st_n = ST_FIN;
        else begin
          cx_n = cx_q - CX_ONE;
          st_n = zf_exit ? ST_FIN : ST_CHECK;
        end
      end
      ST_FIN:  st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q <= ST_IDLE;  op_q <= OP_MOVE; rep_q <= RP_NONE;
      wide_q <= 1'b0;   dir_q <= 1'b0;
      si_q <= '0; di_q <= '0; cx_q <= '0;
      acc_q <= '0; flg_q <= '0; opa_q <= '0; opb_q <= '0;
    end else begin
      st_q <= st_n;     op_q <= op_n;    rep_q <= rep_n;
      wide_q <= wide_n; dir_q <= dir_n;
      si_q <= si_n; di_q <= di_n; cx_q <= cx_n;
      acc_q <= acc_n; flg_q <= flg_n; opa_q <= opa_n; opb_q <= opb_n;
    end
  end

  assign si_out    = si_q;
  assign di_out    = di_q;
  assign cx_out    = cx_q;
  assign acc_out   = acc_q;
  assign flags_out = flg_q;

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> !done);

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_ns)
    !busy |-> !mem_req);

  assert_count_dec_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    ($past(busy) && !$stable(cx_q)) |-> (cx_q == $past(cx_q) - CX_ONE));

  assert_count_kept_R12: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy && rep_q == RP_NONE) |=> $stable(cx_q));

  assert_zero_entry_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    (done && $past(st_q == ST_CHECK)) |->
      ($stable(si_q) && $stable(di_q) && $stable(cx_q) && $stable(acc_q)));

  assert_si_step_R1: assert property (@(posedge clk) disable iff (!rst_ns)
    ($past(busy) && !$stable(si_q)) |->
      (si_q == ($past(dir_q) ? $past(si_q) - (wide_q ? A_TWO : A_ONE)
                             : $past(si_q) + (wide_q ? A_TWO : A_ONE))));

  assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy && !is_cmp) |=> $stable(flg_q));
endmodule

// File: tb/strop_seq_test.sv
`timescale 1ns/1ps
module strop_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  op_sel;
  logic        wide;
  logic [1:0]  rep_sel;
  logic        dir;
  logic [15:0] si_in, di_in, cx_in, acc_in;
  logic [5:0]  flags_in;
  logic        mem_req, mem_we, mem_rdy;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        busy, done;
  logic [15:0] si_out, di_out, cx_out, acc_out;
  logic [5:0]  flags_out;

  logic [7:0]  mem   [0:255];
  logic [7:0]  r_mem [0:255];
  int          xcnt;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  strop_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .wide(wide),
    .rep_sel(rep_sel), .dir(dir), .si_in(si_in), .di_in(di_in), .cx_in(cx_in),
    .acc_in(acc_in), .flags_in(flags_in), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rdy(mem_rdy), .busy(busy), .done(done), .si_out(si_out),
    .di_out(di_out), .cx_out(cx_out), .acc_out(acc_out), .flags_out(flags_out)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_req && mem_rdy) begin
      xcnt <= xcnt + 1;
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  always @(negedge clk) mem_rdy <= (($urandom % 4) != 0);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] sub_flags(input logic [15:0] a, input logic [15:0] b,
                                           input logic w);
    int unsigned msk, ua, ub, r;
    int          sa, sb, sd, lim;
    logic [5:0]  f;
    msk = w ? 32'hFFFF : 32'hFF;
    ua  = a & msk;
    ub  = b & msk;
    r   = (ua - ub) & msk;
    sa  = w ? int'($signed(a)) : int'($signed(a[7:0]));
    sb  = w ? int'($signed(b)) : int'($signed(b[7:0]));
    sd  = sa - sb;
    lim = w ? 32768 : 128;
    f    = '0;
    f[0] = (ua < ub);
    f[1] = ($countones(r[7:0]) % 2) == 0;
    f[2] = (a[3:0] < b[3:0]);
    f[3] = (r == 0);
    f[4] = w ? r[15] : r[7];
    f[5] = (sd >= lim) || (sd < -lim);
    return f;
  endfunction

  function automatic logic [15:0] rd(input logic [15:0] ad, input logic w);
    logic [15:0] ad1;
    ad1 = ad + 16'd1;
    return w ? {r_mem[ad1[7:0]], r_mem[ad[7:0]]} : {8'h00, r_mem[ad[7:0]]};
  endfunction

  task automatic wr(input logic [15:0] ad, input logic [15:0] v, input logic w);
    logic [15:0] ad1;
    ad1 = ad + 16'd1;
    r_mem[ad[7:0]] = v[7:0];
    if (w) r_mem[ad1[7:0]] = v[15:8];
  endtask

  task automatic model_prim(input logic [2:0] op, input logic w, input logic dr,
                            inout logic [15:0] ms, inout logic [15:0] md,
                            inout logic [15:0] ma, inout logic [5:0] mf, inout int n);
    logic [15:0] st, x, y;
    int sz;
    sz = w ? 2 : 1;
    st = w ? 16'd2 : 16'd1;
    case (op)
      3'd0: begin x = rd(ms, w); wr(md, x, w); n += 2*sz;
                  ms = dr ? ms - st : ms + st; md = dr ? md - st : md + st; end
      3'd1: begin x = rd(ms, w); y = rd(md, w); mf = sub_flags(x, y, w); n += 2*sz;
                  ms = dr ? ms - st : ms + st; md = dr ? md - st : md + st; end
      3'd2: begin y = rd(md, w); mf = sub_flags(ma, y, w); n += sz;
                  md = dr ? md - st : md + st; end
      3'd3: begin x = rd(ms, w); ma = w ? x : {ma[15:8], x[7:0]}; n += sz;
                  ms = dr ? ms - st : ms + st; end
      default: begin wr(md, ma, w); n += sz; md = dr ? md - st : md + st; end
    endcase
  endtask

  task automatic run_case(input logic [2:0] op, input logic w, input logic [1:0] rp,
                          input logic dr, input logic [15:0] s, input logic [15:0] d,
                          input logic [15:0] c, input logic [15:0] a,
                          input logic [5:0] f, input string tag);
    logic [15:0] ms, md, mc, ma;
    logic [5:0]  mf;
    int          n, t, bad;
    for (int i = 0; i < 256; i++) r_mem[i] = mem[i];
    ms = s; md = d; mc = c; ma = a; mf = f; n = 0;
    if (rp == 2'd0) model_prim(op, w, dr, ms, md, ma, mf, n);
    else begin
      while (mc != 16'd0) begin
        model_prim(op, w, dr, ms, md, ma, mf, n);
        mc = mc - 16'd1;
        if ((op == 3'd1 || op == 3'd2) &&
            ((rp == 2'd2 && !mf[3]) || (rp == 2'd3 && mf[3]))) break;
      end
    end
    xcnt = 0;
    op_sel = op; wide = w; rep_sel = rp; dir = dr;
    si_in = s; di_in = d; cx_in = c; acc_in = a; flags_in = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (done !== 1'b1 && t < 4000) begin @(negedge clk); t++; end
    chk(tag, "completion", {31'd0, done}, 32'd1);
    chk(tag, "si", {16'd0, si_out}, {16'd0, ms});
    chk(tag, "di", {16'd0, di_out}, {16'd0, md});
    chk(tag, "cx", {16'd0, cx_out}, {16'd0, mc});
    chk(tag, "acc", {16'd0, acc_out}, {16'd0, ma});
    chk(tag, "flags", {26'd0, flags_out}, {26'd0, mf});
    chk(tag, "transfers", xcnt, n);
    bad = -1;
    for (int i = 0; i < 256; i++) if (mem[i] !== r_mem[i] && bad < 0) bad = i;
    chk(tag, "memory", bad, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R13", "done pulse width", {31'd0, done}, 32'd0);
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL R13 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] op;
    logic [1:0] rp;
    logic [15:0] acc;
    bit narrow;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; op_sel = '0; wide = 1'b0; rep_sel = '0; dir = 1'b0;
    si_in = '0; di_in = '0; cx_in = '0; acc_in = '0; flags_in = '0; xcnt = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk("R13", "reset busy", {31'd0, busy}, 32'd0);
    chk("R13", "reset req", {31'd0, mem_req}, 32'd0);
    chk("R13", "reset si/di", {si_out, di_out}, 32'd0);
    chk("R13", "reset cx/acc", {cx_out, acc_out}, 32'd0);

    // R11: zero count under a prefix
    run_case(3'd0, 1'b1, 2'd1, 1'b0, 16'h0020, 16'h0080, 16'd0, 16'h55AA, 6'h15, "R11");
    chk("R11", "no transfer", xcnt, 0);
    run_case(3'd1, 1'b0, 2'd2, 1'b1, 16'h0030, 16'h0090, 16'd0, 16'h0000, 6'h2A, "R11");

    // R12: no prefix with count zero still runs once
    run_case(3'd0, 1'b1, 2'd0, 1'b0, 16'h0010, 16'h0070, 16'd0, 16'h0000, 6'h00, "R12");
    chk("R12", "cx kept", {16'd0, cx_out}, 32'd0);

    // R7: word load across the top of the index range
    mem[8'hFF] = 8'h34; mem[8'h00] = 8'h12;
    run_case(3'd3, 1'b1, 2'd0, 1'b0, 16'hFFFF, 16'h0000, 16'd7, 16'h0000, 6'h00, "R7");
    chk("R7", "little-endian word", {16'd0, acc_out}, 32'h1234);
    chk("R7", "wrapped si", {16'd0, si_out}, 32'h0001);

    // R9: repeat-while-equal compare ends on the third byte
    mem[8'h10] = 1; mem[8'h11] = 2; mem[8'h12] = 3; mem[8'h13] = 4; mem[8'h14] = 5;
    mem[8'h40] = 1; mem[8'h41] = 2; mem[8'h42] = 9; mem[8'h43] = 4; mem[8'h44] = 5;
    run_case(3'd1, 1'b0, 2'd2, 1'b0, 16'h0010, 16'h0040, 16'd5, 16'h0000, 6'h00, "R9");
    chk("R9", "early exit count", {16'd0, cx_out}, 32'd2);
    chk("R2", "borrow flag", {31'd0, flags_out[0]}, 32'd1);

    // R9: repeat-while-not-equal scan stops on a match
    mem[8'h60] = 8'h11; mem[8'h61] = 8'h77; mem[8'h62] = 8'h22;
    run_case(3'd2, 1'b0, 2'd3, 1'b0, 16'h0000, 16'h0060, 16'd6, 16'h0077, 6'h00, "R9");
    chk("R3", "zero flag on match", {31'd0, flags_out[3]}, 32'd1);
    chk("R9", "stop count", {16'd0, cx_out}, 32'd4);

    // R10: store under repeat-while-not-equal runs the full count
    run_case(3'd4, 1'b1, 2'd3, 1'b1, 16'h0000, 16'h00C0, 16'd3, 16'hBEEF, 6'h00, "R10");
    chk("R10", "transfers", xcnt, 6);

    // R1, R5: word move going down
    run_case(3'd0, 1'b1, 2'd1, 1'b1, 16'h0050, 16'h00A0, 16'd4, 16'h0000, 6'h3F, "R5");
    chk("R1", "si descending", {16'd0, si_out}, 32'h0048);

    // Constrained random mix: R1 R2 R3 R4 R5 R6 R8
    for (int k = 0; k < 300; k++) begin
      narrow = ($urandom % 2) == 0;
      for (int i = 0; i < 256; i++) mem[i] = narrow ? 8'($urandom % 2) : 8'($urandom);
      op  = 3'($urandom % 5);
      rp  = 2'($urandom % 4);
      acc = narrow ? 16'($urandom % 2) : 16'($urandom);
      run_case(op, 1'($urandom), rp, 1'($urandom), 16'($urandom), 16'($urandom),
               16'($urandom % 7), acc, 6'($urandom),
               (op == 3'd0) ? "R5" : (op == 3'd1) ? "R2" : (op == 3'd2) ? "R3" :
               (op == 3'd3) ? "R4" : "R6");
    end
    chk("R8", "final idle", {31'd0, busy}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule